// File: doc/BRIEF.md
# Averaging Decimating Axis Filter

This block low-pass filters three axes of signed 16-bit sensor samples that arrive on a fixed base-rate strobe. For each axis it sums a window of N = 2^m samples, divides the sum by N with an arithmetic right shift, adds a signed per-axis bias, and loads the result into an output register. One output is produced per window, so the output rate is the base rate divided by N. With a 512 samples-per-second base, m = 0 gives 512 updates per second and m = 11 gives one update every four seconds.

A register port supplies the average factor through a one-cycle write strobe. It also supplies the three bias words, which are held on the inputs. Each bias uses the same scaling as the output, where one LSB is 1/16384 g. A data-ready line stays in its active state and drops to inactive for the single cycle in which fresh data first shows in the output registers. A polarity input selects whether the active state is high or low.

Top module: `avg_decim_filter`

## Requirements
- R1: After reset the average factor is m = 9, so the first update comes after 512 accepted samples. All three outputs read 0x0000 and data-ready is in its active state.
- R2: Each output equals the sum of the last N = 2^m accepted samples of its axis, shifted right arithmetically by m. The shift rounds toward minus infinity.
- R3: A sample is accepted only in a cycle with `sample_valid` high. Exactly N accepted samples make one update, and idle cycles between samples do not count. New data shows in the cycle after the clock edge that takes the N-th sample.
- R4: Each axis adds its signed bias (`null_in`, axis k in bits [16k+15:16k]) to the averaged value before the output is loaded. The bias is sampled at the load edge.
- R5: The sum of average and bias saturates to the range 0x8000..0x7FFF and never wraps.
- R6: A write on `cfg_write` takes the low four bits of `cfg_avg` as m, clamping values above 11 to 11. The write clears every accumulator and the sample counter. A sample presented in the same cycle as the write is discarded, so the next output covers a full new window.
- R7: Data-ready is inactive for exactly one cycle, the first cycle in which a new output value is visible. It is active in every other cycle.
- R8: With `drdy_pol` = 1 the active state of `drdy` is high. With `drdy_pol` = 0 the active state is low.
- R9: Between updates the output registers hold their value, including across writes of the average factor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sample_valid | input | 1 | Base-rate strobe: the sample words are valid this cycle |
| sample_in | input | 48 | Three signed samples, axis k in bits [16k+15:16k] |
| cfg_write | input | 1 | One-cycle write of the average factor |
| cfg_avg | input | 4 | Average factor m written by `cfg_write` |
| null_in | input | 48 | Three signed bias words, axis k in bits [16k+15:16k] |
| drdy_pol | input | 1 | 1 selects an active-high data-ready, 0 an active-low one |
| axis_out | output | 48 | Three filtered, bias-corrected outputs, axis k in bits [16k+15:16k] |
| drdy | output | 1 | Data-ready line |

## Verification
The assertions check several properties on every cycle. The sample counter never leaves the window set by the current m. The stored m never exceeds 11. A configuration write leaves the counter empty with no load pending. An output register changes only on a load. The arithmetic of the average, the floor rounding of negative sums, saturation at both ends, bias addition, clamping of illegal factors and discarding of a sample that collides with a write depend on the data, so only the bench scenarios can show them. The same holds for the exact cycle and polarity of the data-ready drop.

// File: rtl/filt_pkg.sv
package filt_pkg;
    localparam int unsigned AVG_W     = 4;
    localparam int unsigned M_LIMIT   = 11;
    localparam int unsigned M_DEFAULT = 9;
    typedef logic [AVG_W-1:0] m_t;
endpackage

// File: rtl/filt_sat_add.sv
module filt_sat_add #(
    parameter int unsigned DATA_W = 16
) (
    input  logic signed [DATA_W-1:0] a_i,
    input  logic signed [DATA_W-1:0] b_i,
    output logic signed [DATA_W-1:0] y_o
);
    logic signed [DATA_W:0] wide;

    always_comb begin
        wide = {a_i[DATA_W-1], a_i} + {b_i[DATA_W-1], b_i};
        if (wide[DATA_W] != wide[DATA_W-1]) begin
            y_o = wide[DATA_W] ? {1'b1, {(DATA_W-1){1'b0}}} : {1'b0, {(DATA_W-1){1'b1}}};
        end else begin
            y_o = wide[DATA_W-1:0];
        end
    end
endmodule

// File: rtl/filt_decim_ctrl.sv
module filt_decim_ctrl
    import filt_pkg::*;
#(
    parameter int unsigned M_MAX = M_LIMIT,
    parameter int unsigned M_DEF = M_DEFAULT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_write_i,
    input  logic [AVG_W-1:0] cfg_avg_i,
    input  logic             sample_valid_i,
    output m_t               m_o,
    output logic             clear_o,
    output logic             load_o,
    output logic             load_q_o
);
    localparam int unsigned CNT_W = (M_MAX > 0) ? M_MAX : 1;

    typedef struct packed {
        m_t               m;
        logic [CNT_W-1:0] cnt;
        logic             load;
    } ctrl_st_t;

    ctrl_st_t    st_d, st_q;
    logic [31:0] win_end;

    always_comb begin
        st_d      = st_q;
        st_d.load = 1'b0;
        clear_o   = 1'b0;
        load_o    = 1'b0;
        win_end   = (32'd1 << st_q.m) - 32'd1;
        if (cfg_write_i) begin
            st_d.m   = (cfg_avg_i > m_t'(M_MAX)) ? m_t'(M_MAX) : cfg_avg_i;
            st_d.cnt = '0;
            clear_o  = 1'b1;
        end else if (sample_valid_i) begin
            if (32'(st_q.cnt) == win_end) begin
                st_d.cnt  = '0;
                st_d.load = 1'b1;
                load_o    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.m    <= m_t'(M_DEF);
            st_q.cnt  <= '0;
            st_q.load <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign m_o      = st_q.m;
    assign load_q_o = st_q.load;

    assert_cnt_in_window_R3: assert property (@(posedge clk) disable iff (!rst_n)
        32'(st_q.cnt) <= ((32'd1 << st_q.m) - 32'd1));

    assert_m_clamped_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.m <= m_t'(M_MAX));

    assert_cfg_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_write_i |=> (st_q.cnt == '0) && !st_q.load);
endmodule

// File: rtl/filt_axis_accum.sv
module filt_axis_accum
    import filt_pkg::*;
#(
    parameter int unsigned DATA_W = 16,
    parameter int unsigned ACC_W  = 27
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     valid_i,
    input  logic                     load_i,
    input  m_t                       m_i,
    input  logic signed [DATA_W-1:0] sample_i,
    input  logic signed [DATA_W-1:0] null_i,
    output logic signed [DATA_W-1:0] out_o
);
    typedef struct packed {
        logic signed [ACC_W-1:0]  acc;
        logic signed [DATA_W-1:0] out;
    } acc_st_t;

    acc_st_t                  st_d, st_q;
    logic signed [ACC_W-1:0]  sum;
    logic signed [ACC_W-1:0]  shifted;
    logic signed [DATA_W-1:0] avg;
    logic signed [DATA_W-1:0] biased;

    filt_sat_add #(.DATA_W(DATA_W)) u_sat (
        .a_i (avg),
        .b_i (null_i),
        .y_o (biased)
    );

    always_comb begin
        st_d    = st_q;
        sum     = st_q.acc + {{(ACC_W-DATA_W){sample_i[DATA_W-1]}}, sample_i};
        shifted = sum >>> m_i;
        avg     = shifted[DATA_W-1:0];
        if (clear_i) begin
            st_d.acc = '0;
        end else if (load_i) begin
            st_d.acc = '0;
            st_d.out = biased;
        end else if (valid_i) begin
            st_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_o = st_q.out;

    assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(st_q.out));
endmodule

// File: rtl/avg_decim_filter.sv
module avg_decim_filter
    import filt_pkg::*;
#(
    parameter int unsigned DATA_W   = 16,
    parameter int unsigned NUM_AXES = 3,
    parameter int unsigned M_MAX    = M_LIMIT,
    parameter int unsigned M_DEF    = M_DEFAULT
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         sample_valid,
    input  logic [NUM_AXES*DATA_W-1:0]   sample_in,
    input  logic                         cfg_write,
    input  logic [AVG_W-1:0]             cfg_avg,
    input  logic [NUM_AXES*DATA_W-1:0]   null_in,
    input  logic                         drdy_pol,
    output logic [NUM_AXES*DATA_W-1:0]   axis_out,
    output logic                         drdy
);
    localparam int unsigned ACC_W = DATA_W + M_MAX;

    m_t   m_cur;
    logic clear;
    logic load;
    logic load_q;

    filt_decim_ctrl #(.M_MAX(M_MAX), .M_DEF(M_DEF)) u_ctrl (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_write_i    (cfg_write),
        .cfg_avg_i      (cfg_avg),
        .sample_valid_i (sample_valid),
        .m_o            (m_cur),
        .clear_o        (clear),
        .load_o         (load),
        .load_q_o       (load_q)
    );

    for (genvar k = 0; k < NUM_AXES; k++) begin : g_axis
        filt_axis_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
            .clk      (clk),
            .rst_n    (rst_n),
            .clear_i  (clear),
            .valid_i  (sample_valid),
            .load_i   (load),
            .m_i      (m_cur),
            .sample_i (sample_in[k*DATA_W +: DATA_W]),
            .null_i   (null_in[k*DATA_W +: DATA_W]),
            .out_o    (axis_out[k*DATA_W +: DATA_W])
        );
    end

    assign drdy = drdy_pol ? ~load_q : load_q;
endmodule

// File: tb/avg_decim_filter_tb.sv
module avg_decim_filter_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 150000;

    typedef struct packed {
        int m; int s0; int s1;
        int nx; int ny; int nz;
        int ex; int ey; int ez;
    } vec_t;

    localparam int NVEC = 7;
    localparam vec_t VEC [NVEC] = '{
        '{0, 100, 100, 0, 5, -5, 100, 105, 95},
        '{1, 10, -3, 0, 1, -10, 3, 4, -7},
        '{2, -1, -2, 0, 0, 2, -2, -2, 0},
        '{3, 32767, 32767, 1, -1, 0, 32767, 32766, 32767},
        '{4, -32768, -32768, -1, 100, 0, -32768, -32668, -32768},
        '{5, 1000, 2001, 0, -1500, 20000, 1500, 0, 21500},
        '{11, 5, 6, 0, 0, 0, 5, 5, 5}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sample_valid = 1'b0;
    logic [47:0] sample_in = '0;
    logic        cfg_write = 1'b0;
    logic [3:0]  cfg_avg = '0;
    logic [47:0] null_in = '0;
    logic        drdy_pol = 1'b1;
    logic [47:0] axis_out;
    logic        drdy;

    int checks = 0;
    int errors = 0;
    int px = 0, py = 0, pz = 0;

    avg_decim_filter u_dut (
        .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .sample_in(sample_in),
        .cfg_write(cfg_write), .cfg_avg(cfg_avg), .null_in(null_in),
        .drdy_pol(drdy_pol), .axis_out(axis_out), .drdy(drdy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int ax(input int k);
        return int'($signed(axis_out[k*16 +: 16]));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_axes(input string req, input int ex, input int ey, input int ez);
        chk(req, ax(0), ex);
        chk(req, ax(1), ey);
        chk(req, ax(2), ez);
    endtask

    task automatic feed(input int sx, input int sy, input int sz);
        @(negedge clk);
        sample_valid = 1'b1;
        sample_in = {16'(sz), 16'(sy), 16'(sx)};
        @(negedge clk);
        sample_valid = 1'b0;
    endtask

    task automatic cfg(input int v);
        @(negedge clk);
        cfg_write = 1'b1;
        cfg_avg = 4'(v);
        @(negedge clk);
        cfg_write = 1'b0;
    endtask

    task automatic set_null(input int nx, input int ny, input int nz);
        null_in = {16'(nz), 16'(ny), 16'(nx)};
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * WATCHDOG);
        errors++;
        $display("FAIL watchdog actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk_axes("R1 reset output", 0, 0, 0);
        chk("R1 reset drdy active", int'(drdy), 1);
        // R1: default window of 512 samples
        for (int i = 0; i < 511; i++) feed(7, -7, 1);
        chk_axes("R1 no update before 512", 0, 0, 0);
        feed(7, -7, 1);
        chk_axes("R1 default window", 7, -7, 1);
        chk("R7 drdy low on load", int'(drdy), 0);
        @(negedge clk);
        chk("R7 drdy back", int'(drdy), 1);
        px = 7; py = -7; pz = 1;

        // table walk: R2 R3 R4 R5 R7 R9
        for (int e = 0; e < NVEC; e++) begin
            cfg(VEC[e].m);
            set_null(VEC[e].nx, VEC[e].ny, VEC[e].nz);
            for (int i = 0; i < (1 << VEC[e].m); i++) begin
                if (i == (1 << VEC[e].m) - 1) begin
                    chk_axes("R9 hold before window end", px, py, pz);
                    chk("R7 drdy active mid window", int'(drdy), 1);
                end
                if (i % 2 == 0) feed(VEC[e].s0, VEC[e].s0, VEC[e].s0);
                else feed(VEC[e].s1, VEC[e].s1, VEC[e].s1);
                if (i % 3 == 0 && i != (1 << VEC[e].m) - 1) @(negedge clk); // R3 idle gap
            end
            chk_axes("R2 R4 R5 window result", VEC[e].ex, VEC[e].ey, VEC[e].ez);
            chk("R7 drdy inactive one cycle", int'(drdy), 0);
            @(negedge clk);
            chk("R7 drdy active after", int'(drdy), 1);
            px = VEC[e].ex; py = VEC[e].ey; pz = VEC[e].ez;
        end

        // R6: write mid-window restarts, colliding sample discarded
        set_null(0, 0, 0);
        cfg(2);
        feed(1000, 1000, 1000);
        feed(1000, 1000, 1000);
        @(negedge clk);
        cfg_write = 1'b1; cfg_avg = 4'd2;
        sample_valid = 1'b1; sample_in = {16'd9999, 16'd9999, 16'd9999};
        @(negedge clk);
        cfg_write = 1'b0; sample_valid = 1'b0;
        chk_axes("R9 hold across cfg write", px, py, pz);
        for (int i = 0; i < 3; i++) feed(8, 8, 8);
        chk_axes("R6 restart no early update", px, py, pz);
        feed(8, 8, 8);
        chk_axes("R6 fresh window", 8, 8, 8);
        px = 8; py = 8; pz = 8;

        // R8: active-low polarity
        drdy_pol = 1'b0;
        @(negedge clk);
        chk("R8 idle level active low", int'(drdy), 0);
        // R6: factor 15 clamps to 11
        cfg(15);
        for (int i = 0; i < 2047; i++) feed(3, 4, -3);
        chk_axes("R6 clamp no early update", px, py, pz);
        feed(3, 4, -3);
        chk_axes("R6 clamp to 2048 window", 3, 4, -3);
        chk("R8 inactive level high", int'(drdy), 1);
        @(negedge clk);
        chk("R8 active level low", int'(drdy), 0);

        finish_run();
    end
endmodule